// File: doc/BRIEF.md
# Register-Fed Transmit Packet FIFO

A processor writes 32-bit words, one per bus write, into a data register of this block. The block holds them in a word store and sends nothing yet. When the processor then writes the packet size in bytes to a length register, the words written since the previous commit become one packet. That packet leaves on an AXI4-Stream master port, with TLAST on its final word. Packets that are already committed drain in order while new words build up behind them. A vacancy register reports how many more words can be accepted. The usable space is four words less than the physical depth.

Writing the key value 0xA5 to a reset register flushes everything: stored words, words not yet committed and committed packets. The block pulses single-cycle event outputs for six things: a packet has fully left, a data write was dropped for lack of room, a length disagreed with the words written, a flush has completed, occupancy has risen to the full threshold, and occupancy has fallen to the empty threshold.

A three-state controller sequences the block. ST_IDLE means no committed word waits. ST_STREAM means TVALID is raised on a committed word. ST_FLUSH is the one cycle that follows a key write. The transitions are:
- IDLE→STREAM when a commit leaves committed words.
- STREAM→IDLE when the last committed word is accepted.
- IDLE/STREAM→FLUSH on a key write.
- FLUSH→IDLE unconditionally.

Top module: `txpkt_fifo`

## Requirements
- R1: After reset, m_tvalid is 0, all event outputs are 0, and the vacancy reads DEPTH-4 (12 with defaults).
- R2: A bus write to offset 0x10 stores one word and lowers the vacancy by one. No stream output appears for it until a commit.
- R3: A bus write to offset 0x14 commits all words written since the previous commit as one packet. The words leave in write order, with m_tlast high on the final word only.
- R4: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata and m_tlast hold their values.
- R5: ev_tx_done pulses for one cycle, in the cycle after the final word of a packet is accepted. A word written in the same cycle as that handshake is still stored.
- R6: A data write when the vacancy is 0 drops the word and pulses ev_overrun in the next cycle. The vacancy stays 0.
- R7: ev_len_err pulses in the cycle after a length write when the byte count is 0 or ceil(bytes/4) differs from the number of uncommitted words. Any uncommitted words are still released as a packet.
- R8: Writing 0xA5 to offset 0x08 empties the block. In the next cycle, ev_rst_done is 1, m_tvalid is 0 and the vacancy is DEPTH-4. Any other value at 0x08 has no effect.
- R9: Bus writes made during the ev_rst_done cycle (state ST_FLUSH) are ignored.
- R10: Several committed packets drain back to back in commit order.
- R11: ev_prog_full pulses when occupancy rises from below FULL_AT to at least FULL_AT. ev_prog_empty pulses when occupancy falls from above EMPTY_AT to at most EMPTY_AT.
- R12: A read at rd_addr 0x0C returns the vacancy in the low bits. Any other rd_addr returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write byte offset |
| wr_data | input | 32 | Bus write data |
| rd_addr | input | 8 | Bus read byte offset |
| rd_data | output | 32 | Bus read data (vacancy at 0x0C) |
| m_tdata | output | 32 | Stream data |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| m_tlast | output | 1 | Final word of packet |
| ev_tx_done | output | 1 | Packet fully sent pulse |
| ev_overrun | output | 1 | Dropped data write pulse |
| ev_len_err | output | 1 | Length mismatch pulse |
| ev_rst_done | output | 1 | Flush complete pulse |
| ev_prog_full | output | 1 | Occupancy reached full threshold |
| ev_prog_empty | output | 1 | Occupancy fell to empty threshold |

## Verification
Two operations can fall in the same clock edge:
- a push from the bus side;
- a pop of the final word of a packet from the stream side.

The bench provokes this by raising m_tready in the same cycle as a data write, while a one-word packet is pending. It then judges the result:
- the vacancy must be unchanged;
- ev_tx_done must pulse;
- the new word must later come out as its own packet.

A second overlap is a key write while a word is stalled on the stream port. It is judged by TVALID dropping together with the flush pulse.

// File: rtl/txpkt_fifo_pkg.sv
package txpkt_fifo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_FLUSH  = 2'd2
    } txf_state_e;

    localparam logic [7:0]  OFS_RESET   = 8'h08;
    localparam logic [7:0]  OFS_VACANCY = 8'h0C;
    localparam logic [7:0]  OFS_DATA    = 8'h10;
    localparam logic [7:0]  OFS_LENGTH  = 8'h14;
    localparam logic [31:0] FLUSH_KEY   = 32'h0000_00A5;
    localparam int          SLACK_WORDS = 4;

endpackage

// File: rtl/txpkt_fifo_store.sv
module txpkt_fifo_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              mark_last,
    output logic [DATA_W-1:0] head_data,
    output logic              head_last
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  last_vec;
    logic [AW-1:0]     wr_ptr_q;
    logic [AW-1:0]     rd_ptr_q;
    logic [AW-1:0]     tail_ptr;

    assign tail_ptr = wr_ptr_q - 1'b1;

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic slot_last_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_last_q <= 1'b0;
            end else if (push && wr_ptr_q == AW'(i)) begin
                slot_last_q <= 1'b0;
            end else if (mark_last && tail_ptr == AW'(i)) begin
                slot_last_q <= 1'b1;
            end
        end
        assign last_vec[i] = slot_last_q;
    end

    assign head_data = mem_q[rd_ptr_q];
    assign head_last = last_vec[rd_ptr_q];

endmodule

// File: rtl/txpkt_fifo_ctrl.sv
module txpkt_fifo_ctrl
    import txpkt_fifo_pkg::*;
#(
    parameter int CAP = 12,
    parameter int CW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic          tready,
    input  logic          head_last,
    output logic          push,
    output logic          pop,
    output logic          mark_last,
    output logic          flush,
    output logic          tvalid,
    output logic [CW-1:0] occ,
    output logic          ev_done,
    output logic          ev_overrun,
    output logic          ev_len_err,
    output logic          ev_rst_done
);
    txf_state_e    state_q, state_d;
    logic [CW-1:0] occ_q, occ_d;
    logic [CW-1:0] pend_q, pend_d;
    logic [CW-1:0] cmt_q, cmt_d;
    logic          in_flush, hit_data, hit_len, commit, len_bad, overrun_c;
    logic [32:0]   req_words;

    // bus decode, all writes ignored during the flush cycle
    always_comb begin
        in_flush  = (state_q == ST_FLUSH);
        hit_data  = wr_en && !in_flush && (wr_addr == OFS_DATA);
        hit_len   = wr_en && !in_flush && (wr_addr == OFS_LENGTH);
        flush     = wr_en && !in_flush && (wr_addr == OFS_RESET) && (wr_data == FLUSH_KEY);
        push      = hit_data && (occ_q != CW'(CAP));
        overrun_c = hit_data && (occ_q == CW'(CAP));
        commit    = hit_len && (pend_q != '0);
        mark_last = commit;
        req_words = ({1'b0, wr_data} + 33'd3) >> 2;
        len_bad   = hit_len && ((wr_data == '0) ||
                    (req_words != {{(33-CW){1'b0}}, pend_q}));
        tvalid    = (state_q == ST_STREAM);
        pop       = tvalid && tready;
    end

    // counters of stored, uncommitted and committed words
    always_comb begin
        occ_d  = occ_q;
        pend_d = pend_q;
        cmt_d  = cmt_q;
        if (flush) begin
            occ_d  = '0;
            pend_d = '0;
            cmt_d  = '0;
        end else begin
            occ_d = occ_q + CW'(push) - CW'(pop);
            if (commit) begin
                pend_d = '0;
            end else if (push) begin
                pend_d = pend_q + 1'b1;
            end
            cmt_d = cmt_q + (commit ? pend_q : '0) - CW'(pop);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_STREAM: begin
                if (flush) begin
                    state_d = ST_FLUSH;
                end else if (cmt_d != '0) begin
                    state_d = ST_STREAM;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_FLUSH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            occ_q   <= '0;
            pend_q  <= '0;
            cmt_q   <= '0;
        end else begin
            state_q <= state_d;
            occ_q   <= occ_d;
            pend_q  <= pend_d;
            cmt_q   <= cmt_d;
        end
    end

    // registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_done    <= 1'b0;
            ev_overrun <= 1'b0;
            ev_len_err <= 1'b0;
        end else begin
            ev_done    <= pop && head_last;
            ev_overrun <= overrun_c;
            ev_len_err <= len_bad;
        end
    end

    assign ev_rst_done = in_flush;
    assign occ         = occ_q;

endmodule

// File: rtl/txpkt_fifo_level.sv
module txpkt_fifo_level #(
    parameter int CW       = 4,
    parameter int FULL_AT  = 10,
    parameter int EMPTY_AT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] occ,
    output logic          ev_full,
    output logic          ev_empty
);
    localparam logic [CW-1:0] FULL_LVL  = CW'(FULL_AT);
    localparam logic [CW-1:0] EMPTY_LVL = CW'(EMPTY_AT);

    logic [CW-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= occ;
    end

    assign ev_full  = (occ >= FULL_LVL)  && (prev_q < FULL_LVL);
    assign ev_empty = (occ <= EMPTY_LVL) && (prev_q > EMPTY_LVL);

endmodule

// File: rtl/txpkt_fifo.sv
module txpkt_fifo
    import txpkt_fifo_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int FULL_AT  = 10,
    parameter int EMPTY_AT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [7:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic [31:0] m_tdata,
    output logic        m_tvalid,
    input  logic        m_tready,
    output logic        m_tlast,
    output logic        ev_tx_done,
    output logic        ev_overrun,
    output logic        ev_len_err,
    output logic        ev_rst_done,
    output logic        ev_prog_full,
    output logic        ev_prog_empty
);
    localparam int CAP = DEPTH - SLACK_WORDS;
    localparam int CW  = $clog2(CAP + 1);

    logic          push, pop, mark_last, flush, head_last;
    logic [CW-1:0] occ;
    logic [CW-1:0] vac;

    txpkt_fifo_ctrl #(.CAP(CAP), .CW(CW)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tready     (m_tready),
        .head_last  (head_last),
        .push       (push),
        .pop        (pop),
        .mark_last  (mark_last),
        .flush      (flush),
        .tvalid     (m_tvalid),
        .occ        (occ),
        .ev_done    (ev_tx_done),
        .ev_overrun (ev_overrun),
        .ev_len_err (ev_len_err),
        .ev_rst_done(ev_rst_done)
    );

    txpkt_fifo_store #(.DATA_W(32), .DEPTH(DEPTH)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (push),
        .push_data(wr_data),
        .pop      (pop),
        .mark_last(mark_last),
        .head_data(m_tdata),
        .head_last(head_last)
    );

    txpkt_fifo_level #(.CW(CW), .FULL_AT(FULL_AT), .EMPTY_AT(EMPTY_AT)) level_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .occ     (occ),
        .ev_full (ev_prog_full),
        .ev_empty(ev_prog_empty)
    );

    assign m_tlast = head_last;
    assign vac     = CW'(CAP) - occ;
    assign rd_data = (rd_addr == OFS_VACANCY) ? {{(32-CW){1'b0}}, vac} : 32'd0;

endmodule

// File: rtl/txpkt_fifo_checker.sv
module txpkt_fifo_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [7:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic [31:0] m_tdata,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic        m_tlast,
    input logic        ev_tx_done,
    input logic        ev_overrun,
    input logic        ev_len_err,
    input logic        ev_rst_done
);
    logic key_wr;
    assign key_wr = wr_en && (wr_addr == 8'h08) && (wr_data == 32'h0000_00A5);

    a_r4_hold_stalled_word: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready && !key_wr) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_done |-> $past(m_tvalid && m_tready && m_tlast));

    a_r6_overrun_from_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overrun |-> $past(wr_en && wr_addr == 8'h10));

    a_r7_len_err_from_length_write: assert property (@(posedge clk) disable iff (!rst_n)
        ev_len_err |-> $past(wr_en && wr_addr == 8'h14));

    a_r8_rst_done_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rst_done |-> $past(key_wr));

    a_r8_key_starts_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !ev_rst_done) |=> ev_rst_done);

    a_r9_flush_blocks_stream: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rst_done |-> !m_tvalid);

    a_r8_bus_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_overrun, ev_len_err, ev_rst_done}));

endmodule

bind txpkt_fifo txpkt_fifo_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .m_tdata    (m_tdata),
    .m_tvalid   (m_tvalid),
    .m_tready   (m_tready),
    .m_tlast    (m_tlast),
    .ev_tx_done (ev_tx_done),
    .ev_overrun (ev_overrun),
    .ev_len_err (ev_len_err),
    .ev_rst_done(ev_rst_done)
);

// File: tb/txpkt_fifo_tb_top.sv
module txpkt_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h0C;
    logic [31:0] rd_data;
    logic [31:0] m_tdata;
    logic        m_tvalid;
    logic        m_tready = 1'b0;
    logic        m_tlast;
    logic        ev_tx_done, ev_overrun, ev_len_err, ev_rst_done, ev_prog_full, ev_prog_empty;

    int n_chk  = 0;
    int n_fail = 0;
    int pe_seen = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    txpkt_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tlast(m_tlast), .ev_tx_done(ev_tx_done),
        .ev_overrun(ev_overrun), .ev_len_err(ev_len_err), .ev_rst_done(ev_rst_done),
        .ev_prog_full(ev_prog_full), .ev_prog_empty(ev_prog_empty)
    );

    always @(negedge clk) if (ev_prog_empty) pe_seen++;

    // {addr, data, expected vacancy, expected length error}
    localparam logic [48:0] VEC [9] = '{
        {8'h10, 32'h0000_0100, 8'd11, 1'b0},
        {8'h10, 32'h0000_0101, 8'd10, 1'b0},
        {8'h10, 32'h0000_0102, 8'd9,  1'b0},
        {8'h14, 32'd12,        8'd9,  1'b0},
        {8'h08, 32'h0000_005A, 8'd9,  1'b0},
        {8'h10, 32'h0000_0200, 8'd8,  1'b0},
        {8'h10, 32'h0000_0201, 8'd7,  1'b0},
        {8'h14, 32'd8,         8'd7,  1'b0},
        {8'h14, 32'd4,         8'd7,  1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic take(input int n, input logic [31:0] base, input string req);
        m_tready = 1'b1;
        for (int k = 0; k < n; k++) begin
            for (int w = 0; w < 50 && !m_tvalid; w++) @(negedge clk);
            check({req, " tvalid"}, 32'(m_tvalid), 32'd1);
            check({req, " tdata"}, m_tdata, base + 32'(k));
            check({req, " tlast"}, 32'(m_tlast), 32'(k == n - 1));
            @(negedge clk);
        end
        check("R5 tx_done after final word", 32'(ev_tx_done), 32'd1);
        m_tready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int pe0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tvalid", 32'(m_tvalid), 32'd0);
        check("R1 vacancy", rd_data, 32'd12);
        check("R1 events", {26'd0, ev_tx_done, ev_overrun, ev_len_err, ev_rst_done,
                            ev_prog_full, ev_prog_empty}, 32'd0);
        rd_addr = 8'h10;
        #1 check("R12 other offset reads zero", rd_data, 32'd0);
        rd_addr = 8'h0C;

        // table: R2 pushes, R3 commits, R8 wrong key ignored, R7 zero pending
        pe0 = pe_seen;
        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][48:41], VEC[i][40:9]);
            check("R2 vacancy after table write", rd_data, 32'(VEC[i][8:1]));
            check("R7 length error flag in table", 32'(ev_len_err), 32'(VEC[i][0]));
        end
        // R4 stalled word holds
        check("R4 tvalid", 32'(m_tvalid), 32'd1);
        repeat (3) @(negedge clk);
        check("R4 held tdata", m_tdata, 32'h100);
        check("R4 held tlast", 32'(m_tlast), 32'd0);
        take(3, 32'h100, "R3");
        take(2, 32'h200, "R10");
        check("R11 prog empty once on drain", 32'(pe_seen - pe0), 32'd1);
        check("R2 vacancy back", rd_data, 32'd12);

        // R2 no output before commit
        wr(8'h10, 32'h300);
        check("R2 no tvalid before commit", 32'(m_tvalid), 32'd0);
        wr(8'h14, 32'd4);
        // push and final-word pop in one cycle (R5)
        m_tready = 1'b1; wr_en = 1'b1; wr_addr = 8'h10; wr_data = 32'h400;
        @(negedge clk);
        wr_en = 1'b0; m_tready = 1'b0;
        check("R5 tx_done with push", 32'(ev_tx_done), 32'd1);
        check("R5 vacancy unchanged", rd_data, 32'd11);
        check("R5 no tvalid after", 32'(m_tvalid), 32'd0);
        wr(8'h14, 32'd4);
        take(1, 32'h400, "R5");

        // fill, R11 full and R6 overrun
        for (int i = 0; i < 12; i++) begin
            wr(8'h10, 32'h500 + 32'(i));
            if (i == 8) check("R11 no prog full early", 32'(ev_prog_full), 32'd0);
            if (i == 9) check("R11 prog full at threshold", 32'(ev_prog_full), 32'd1);
        end
        check("R6 vacancy zero", rd_data, 32'd0);
        wr(8'h10, 32'h5FF);
        check("R6 overrun event", 32'(ev_overrun), 32'd1);
        check("R6 vacancy stays zero", rd_data, 32'd0);
        wr(8'h14, 32'd48);
        check("R7 exact length no error", 32'(ev_len_err), 32'd0);
        pe0 = pe_seen;
        take(12, 32'h500, "R6");
        check("R6 dropped word absent", 32'(m_tvalid), 32'd0);
        check("R11 prog empty on full drain", 32'(pe_seen - pe0), 32'd1);

        // R7 mismatch still releases words; rounding of odd byte count
        wr(8'h10, 32'h600); wr(8'h10, 32'h601); wr(8'h14, 32'd4);
        check("R7 mismatch event", 32'(ev_len_err), 32'd1);
        take(2, 32'h600, "R7");
        wr(8'h10, 32'h700); wr(8'h10, 32'h701); wr(8'h14, 32'd6);
        check("R7 rounded length no error", 32'(ev_len_err), 32'd0);
        take(2, 32'h700, "R7");

        // R8 flush with stalled word, R9 writes during flush ignored
        wr(8'h10, 32'h800); wr(8'h10, 32'h801); wr(8'h14, 32'd8); wr(8'h10, 32'h802);
        check("R8 stalled before key", 32'(m_tvalid), 32'd1);
        wr(8'h08, 32'hA5);
        check("R8 rst_done pulse", 32'(ev_rst_done), 32'd1);
        check("R8 tvalid dropped", 32'(m_tvalid), 32'd0);
        check("R8 vacancy restored", rd_data, 32'd12);
        wr(8'h10, 32'h777);
        check("R9 write in flush ignored", rd_data, 32'd12);
        check("R9 rst_done single cycle", 32'(ev_rst_done), 32'd0);
        wr(8'h14, 32'd4);
        check("R9 nothing pending after flush", 32'(ev_len_err), 32'd1);
        check("R9 no stream after flush", 32'(m_tvalid), 32'd0);
        wr(8'h10, 32'h900); wr(8'h14, 32'd4);
        take(1, 32'h900, "R8");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule